// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor built around one accumulator. It repeats the same loop for every instruction: fetch a word from memory, split it into an operation code and an address, then carry out the operation. Every step is an explicit move between internal registers: a program counter, a memory address register, a memory buffer register, an instruction register, the accumulator and a three-bit status register.

Program and data share one synchronous memory outside the block. The core reaches it through a single port with an address, write data, read data and a write enable. A read returns data one cycle after the address is presented. The ALU supports load, add, subtract, AND and OR on a word read from memory. Store, an unconditional jump and a jump on zero complete the instruction set, and a halt instruction stops the loop until reset.

A halted output and a cycle counter let the surrounding system tell when a program has finished and how long it took.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, flags, address, buffer and instruction registers and the cycle counter. It restarts the fetch loop. While reset is held, `mem_addr` is 0, `mem_we` is 0, `halted` is 0 and `acc_out` and `flags_out` are 0.
- R2: Fetch runs in four cycles:
  - The program counter is copied to the address register.
  - One cycle is given to the memory read.
  - The read word is captured in the buffer register, and the program counter is incremented in that same cycle.
  - The buffer register is copied to the instruction register.

  Two consequences follow. After the first clock edge following reset, `mem_addr` shows 0. After the sixth edge of a program starting with a NOP, it shows 1. The program counter wraps from 15 to 0.
- R3: Decode splits the 8-bit instruction into an upper 4-bit opcode and a lower 4-bit direct address. The opcodes are:

  | Code | Operation |
  |------|-----------|
  | 0 | NOP |
  | 1 | LOAD |
  | 2 | STORE |
  | 3 | ADD |
  | 4 | SUB |
  | 5 | AND |
  | 6 | OR |
  | 7 | JMP |
  | 8 | JZ |
  | F | HALT |
- R4: LOAD copies the addressed memory word into the accumulator and updates only the zero flag. Carry and overflow keep their values.
- R5: STORE places the accumulator on `mem_wdata`, with `mem_addr` equal to the operand, and raises `mem_we` for exactly one cycle. Flags are unchanged. `mem_we` is never high for any other opcode.
- R6: ADD sets the accumulator to accumulator plus memory word. Carry is the bit out of bit 7, overflow is the two's-complement overflow, and zero is set when the result is 0.
- R7: SUB sets the accumulator to accumulator minus memory word. Carry is set when a borrow occurs (the accumulator is unsigned-less than the word). Overflow is the signed overflow of the subtraction, and zero is set when the result is 0.
- R8: AND and OR combine the accumulator with the memory word bitwise. They set zero from the result and clear carry and overflow.
- R9: JMP loads the program counter with the operand. JZ does the same only when the zero flag is 1. Neither changes the accumulator or the flags.
- R10: NOP and the unused opcodes 9 to E change nothing except advancing the program counter.
- R11: HALT raises `halted` and holds it until reset. While halted, the accumulator, flags and cycle count do not change and no memory write occurs.
- R12: `cycle_cnt` counts the clock edges since reset at which the core was not halted. Each instruction costs a fixed number of cycles:
  - NOP, JMP, JZ, HALT and the unused opcodes take 5 cycles.
  - STORE takes 7 cycles.
  - LOAD, ADD, SUB, AND and OR take 9 cycles.
- R13: `flags_out` bit 0 is zero, bit 1 is carry and bit 2 is overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Memory address, driven by the address register |
| mem_wdata | output | DW | Memory write data, driven by the buffer register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Memory read data, valid one cycle after the address |
| acc_out | output | DW | Accumulator value |
| flags_out | output | 3 | Status flags: bit 0 zero, bit 1 carry, bit 2 overflow |
| halted | output | 1 | High once a HALT has been decoded |
| cycle_cnt | output | CW | Non-halted cycles since reset, saturating |

## Verification
A wrong sequencer state shows up at once as an incorrect `mem_addr` or a misplaced `mem_we` pulse, and as an early or late `halted`, visible in `cycle_cnt` when the program ends. A corrupted program counter or decode sends execution down the wrong path. That shows up in the final accumulator and memory image within one instruction, or as a run that never halts. Flag faults surface through later JZ decisions and through the flag value read when the program completes. Self-modifying and wrapping programs expose address-register and wrap faults in the stored memory image.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OPW = 4;

   localparam logic [OPW-1:0] OP_NOP   = 4'h0;
   localparam logic [OPW-1:0] OP_LOAD  = 4'h1;
   localparam logic [OPW-1:0] OP_STORE = 4'h2;
   localparam logic [OPW-1:0] OP_ADD   = 4'h3;
   localparam logic [OPW-1:0] OP_SUB   = 4'h4;
   localparam logic [OPW-1:0] OP_AND   = 4'h5;
   localparam logic [OPW-1:0] OP_OR    = 4'h6;
   localparam logic [OPW-1:0] OP_JMP   = 4'h7;
   localparam logic [OPW-1:0] OP_JZ    = 4'h8;
   localparam logic [OPW-1:0] OP_HALT  = 4'hF;

   typedef enum logic [3:0] {
      S_FADDR  = 4'd0,
      S_FWAIT  = 4'd1,
      S_FLOAD  = 4'd2,
      S_FIR    = 4'd3,
      S_DEC    = 4'd4,
      S_XADDR  = 4'd5,
      S_XWAIT  = 4'd6,
      S_XLOAD  = 4'd7,
      S_XALU   = 4'd8,
      S_XWRITE = 4'd9,
      S_HALT   = 4'd10
   } state_t;

   typedef struct packed {
      logic v;
      logic c;
      logic z;
   } flags_t;

   function automatic logic needs_operand(input logic [OPW-1:0] op);
      return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) ||
             (op == OP_SUB)  || (op == OP_AND)   || (op == OP_OR);
   endfunction

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
   import acc_core_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [OPW-1:0] op,
   input  logic [DW-1:0]  a,
   input  logic [DW-1:0]  b,
   input  flags_t         fin,
   output logic [DW-1:0]  res,
   output flags_t         fout
);

   logic [DW:0] sum;
   logic [DW:0] dif;

   assign sum = {1'b0, a} + {1'b0, b};
   assign dif = {1'b0, a} - {1'b0, b};

   always_comb begin
      res  = a;
      fout = fin;
      case (op)
         OP_LOAD: begin
            res    = b;
            fout.z = (b == '0);
         end
         OP_ADD: begin
            res    = sum[DW-1:0];
            fout.c = sum[DW];
            fout.v = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
            fout.z = (sum[DW-1:0] == '0);
         end
         OP_SUB: begin
            res    = dif[DW-1:0];
            fout.c = dif[DW];
            fout.v = (a[DW-1] != b[DW-1]) && (dif[DW-1] != a[DW-1]);
            fout.z = (dif[DW-1:0] == '0);
         end
         OP_AND: begin
            res  = a & b;
            fout = '{v: 1'b0, c: 1'b0, z: ((a & b) == '0)};
         end
         OP_OR: begin
            res  = a | b;
            fout = '{v: 1'b0, c: 1'b0, z: ((a | b) == '0)};
         end
         default: begin
            res  = a;
            fout = fin;
         end
      endcase
   end

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
   import acc_core_pkg::*;
(
   input  logic           clk,
   input  logic           rst,
   input  logic [OPW-1:0] op,
   output state_t         st
);

   state_t nx;

   always_comb begin
      nx = st;
      case (st)
         S_FADDR:  nx = S_FWAIT;
         S_FWAIT:  nx = S_FLOAD;
         S_FLOAD:  nx = S_FIR;
         S_FIR:    nx = S_DEC;
         S_DEC: begin
            if (op == OP_HALT)          nx = S_HALT;
            else if (needs_operand(op)) nx = S_XADDR;
            else                        nx = S_FADDR;
         end
         S_XADDR:  nx = (op == OP_STORE) ? S_XWRITE : S_XWAIT;
         S_XWAIT:  nx = S_XLOAD;
         S_XLOAD:  nx = S_XALU;
         S_XALU:   nx = S_FADDR;
         S_XWRITE: nx = S_FADDR;
         S_HALT:   nx = S_HALT;
         default:  nx = S_FADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= S_FADDR;
      else     st <= nx;
   end

   // R2: fetch steps follow in fixed order
   a_r2_fetch_wait: assert property (@(posedge clk) disable iff (rst)
      (st == S_FADDR) |=> (st == S_FWAIT));
   a_r2_fetch_ir: assert property (@(posedge clk) disable iff (rst)
      (st == S_FLOAD) |=> (st == S_FIR));
   // R11: halt is sticky
   a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
      (st == S_HALT) |=> (st == S_HALT));

endmodule

// File: rtl/acc_core_cyc.sv
module acc_core_cyc #(
   parameter int CW       = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] CNT_ONE = CW'(1);
   localparam logic [CW-1:0] CNT_MAX = '1;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (rst)                        cnt <= '0;
            else if (run && cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst)      cnt <= '0;
            else if (run) cnt <= cnt + CNT_ONE;
         end
      end
   endgenerate

   // R12: count holds while halted
   a_r12_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(cnt));

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int AW           = 4,
   parameter int DW           = 8,
   parameter int CW           = 16,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] acc_out,
   output logic [2:0]    flags_out,
   output logic          halted,
   output logic [CW-1:0] cycle_cnt
);

   localparam logic [AW-1:0] PC_ONE = AW'(1);

   generate
      if (DW != AW + OPW) begin : g_bad_split
         $error("acc_core: DW must equal AW plus the opcode width");
      end
      if (AW < 1 || CW < 1) begin : g_bad_width
         $error("acc_core: AW and CW must be positive");
      end
   endgenerate

   state_t         st;
   logic [AW-1:0]  pc;
   logic [AW-1:0]  mar;
   logic [DW-1:0]  mbr;
   logic [DW-1:0]  cir;
   logic [DW-1:0]  acc;
   flags_t         flg;
   logic [OPW-1:0] op;
   logic [AW-1:0]  opnd;
   logic [DW-1:0]  alu_res;
   flags_t         alu_flg;

   assign op   = cir[DW-1 -: OPW];
   assign opnd = cir[AW-1:0];

   acc_core_ctrl u_ctrl (
      .clk (clk),
      .rst (rst),
      .op  (op),
      .st  (st)
   );

   acc_core_alu #(.DW(DW)) u_alu (
      .op   (op),
      .a    (acc),
      .b    (mbr),
      .fin  (flg),
      .res  (alu_res),
      .fout (alu_flg)
   );

   acc_core_cyc #(.CW(CW), .SATURATE(CNT_SATURATE)) u_cyc (
      .clk (clk),
      .rst (rst),
      .run (st != S_HALT),
      .cnt (cycle_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc  <= '0;
         mar <= '0;
         mbr <= '0;
         cir <= '0;
         acc <= '0;
         flg <= '0;
      end else begin
         case (st)
            S_FADDR: mar <= pc;
            S_FLOAD: begin
               mbr <= mem_rdata;
               pc  <= pc + PC_ONE;
            end
            S_FIR: cir <= mbr;
            S_DEC: begin
               if (op == OP_JMP || (op == OP_JZ && flg.z)) pc <= opnd;
            end
            S_XADDR: begin
               mar <= opnd;
               if (op == OP_STORE) mbr <= acc;
            end
            S_XLOAD: mbr <= mem_rdata;
            S_XALU: begin
               acc <= alu_res;
               flg <= alu_flg;
            end
            default: ;
         endcase
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign mem_we    = (st == S_XWRITE);
   assign acc_out   = acc;
   assign flags_out = flg;
   assign halted    = (st == S_HALT);

   // R2: program counter steps by one when the fetched word is captured
   a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
      (st == S_FLOAD) |=> (pc == $past(pc) + PC_ONE));
   // R5: writes only come from a decoded store
   a_r5_we_store_only: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (op == OP_STORE));
   // R5: store leaves flags alone
   a_r5_store_flags: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> $stable(flg));
   // R8: logic ops clear carry and overflow
   a_r8_logic_clear: assert property (@(posedge clk) disable iff (rst)
      (st == S_XALU && (op == OP_AND || op == OP_OR)) |=> (!flg.c && !flg.v));
   // R11: accumulator and program counter frozen while halted
   a_r11_halt_hold: assert property (@(posedge clk) disable iff (rst)
      halted |=> ($stable(acc) && $stable(pc) && !mem_we));

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic [DW-1:0] mem_rdata;
   logic [DW-1:0] acc_out;
   logic [2:0]    flags_out;
   logic          halted;
   logic [CW-1:0] cycle_cnt;

   always #5 clk = ~clk;

   logic [DW-1:0] mem [16];

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   acc_core #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .acc_out   (acc_out),
      .flags_out (flags_out),
      .halted    (halted),
      .cycle_cnt (cycle_cnt)
   );

   int total = 0;
   int fails = 0;
   int wd = 0;

   logic [7:0] prog  [16];
   logic [7:0] r_mem [16];
   logic [7:0] r_acc;
   logic [2:0] r_flg;
   int         r_cyc;

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd == 150000) begin
         total++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected<150000", wd);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference interpreter; flags packed as {v,c,z} (R13)
   task automatic run_model(output bit done);
      logic [3:0] pc = '0;
      logic [7:0] a  = '0;
      logic z = 0, c = 0, v = 0;
      logic [8:0] w;
      int cy = 0;
      done = 0;
      for (int i = 0; i < 16; i++) r_mem[i] = prog[i];
      for (int s = 0; s < 60 && !done; s++) begin
         logic [7:0] ir = r_mem[pc];
         logic [3:0] op = ir[7:4];
         logic [3:0] ad = ir[3:0];
         logic [7:0] b  = r_mem[ad];
         pc = pc + 4'd1;
         case (op)
            4'h1: begin a = b; z = (a == 0); cy += 9; end
            4'h2: begin r_mem[ad] = a; cy += 7; end
            4'h3: begin
               w = {1'b0, a} + {1'b0, b};
               v = (a[7] == b[7]) && (w[7] != a[7]);
               a = w[7:0]; c = w[8]; z = (a == 0); cy += 9;
            end
            4'h4: begin
               w = {1'b0, a} - {1'b0, b};
               v = (a[7] != b[7]) && (w[7] != a[7]);
               a = w[7:0]; c = w[8]; z = (a == 0); cy += 9;
            end
            4'h5: begin a = a & b; z = (a == 0); c = 0; v = 0; cy += 9; end
            4'h6: begin a = a | b; z = (a == 0); c = 0; v = 0; cy += 9; end
            4'h7: begin pc = ad; cy += 5; end
            4'h8: begin if (z) pc = ad; cy += 5; end
            4'hF: begin cy += 5; done = 1; end
            default: cy += 5;
         endcase
      end
      r_acc = a;
      r_flg = {v, c, z};
      r_cyc = cy;
   endtask

   task automatic run_prog(input string tag);
      bit ok;
      int n = 0;
      int bad = 0;
      logic [7:0]    h_acc;
      logic [CW-1:0] h_cnt;
      int we_seen = 0;
      run_model(ok);
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 16; i++) mem[i] = prog[i];
      repeat (2) @(negedge clk);
      chk("R1 reset acc", acc_out, 0);
      chk("R1 reset flags", flags_out, 0);
      chk("R1 reset halted/cnt/addr/we", {halted, cycle_cnt, mem_addr, mem_we}, 0);
      rst = 1'b0;
      while (!halted && n < r_cyc + 20) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " R11 halted"}, halted, 1);
      chk({tag, " R12 cycles"}, cycle_cnt, r_cyc);
      chk({tag, " acc"}, acc_out, r_acc);
      chk({tag, " R13 flags"}, flags_out, r_flg);
      for (int i = 0; i < 16; i++) if (mem[i] !== r_mem[i]) bad++;
      chk({tag, " R5 memory mismatches"}, bad, 0);
      h_acc = acc_out;
      h_cnt = cycle_cnt;
      repeat (8) begin
         @(negedge clk);
         if (mem_we) we_seen++;
      end
      chk({tag, " R11 hold"}, {acc_out, cycle_cnt, halted}, {h_acc, h_cnt, 1'b1});
      chk({tag, " R11 no write"}, we_seen, 0);
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 16; i++) prog[i] = 8'h00;
   endtask

   initial begin
      void'($urandom(32'h5EED1));

      // R2 fetch address timing
      clear_prog();
      prog[1] = 8'hF0;
      for (int i = 0; i < 16; i++) mem[i] = prog[i];
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R2 first fetch address", mem_addr, 0);
      repeat (5) @(negedge clk);
      chk("R2 second fetch address", mem_addr, 1);

      // R6 add: 0x80+0x80 gives carry, overflow, zero
      clear_prog();
      prog[0] = 8'h1A; prog[1] = 8'h3B; prog[2] = 8'h2C; prog[3] = 8'hF0;
      prog[10] = 8'h80; prog[11] = 8'h80; prog[12] = 8'h55;
      run_prog("R6 add");
      chk("R6 flags explicit", flags_out, 3'b111);

      // R7 subtract borrow then signed overflow
      clear_prog();
      prog[0] = 8'h1A; prog[1] = 8'h4B; prog[2] = 8'h2C; prog[3] = 8'h1D;
      prog[4] = 8'h4E; prog[5] = 8'hF0;
      prog[10] = 8'h10; prog[11] = 8'h20; prog[13] = 8'h80; prog[14] = 8'h01;
      run_prog("R7 sub");
      chk("R7 result", acc_out, 8'h7F);

      // R8 logic ops clear carry
      clear_prog();
      prog[0] = 8'h1A; prog[1] = 8'h3B; prog[2] = 8'h6C; prog[3] = 8'h5D; prog[4] = 8'hF0;
      prog[10] = 8'hFF; prog[11] = 8'h01; prog[12] = 8'h30; prog[13] = 8'h0F;
      run_prog("R8 logic");
      chk("R8 zero only", flags_out, 3'b001);

      // R9 jumps
      clear_prog();
      prog[0] = 8'h1C; prog[1] = 8'h85; prog[2] = 8'h1D; prog[3] = 8'hF0;
      prog[4] = 8'hF0; prog[5] = 8'h78; prog[6] = 8'hF0; prog[7] = 8'hF0;
      prog[8] = 8'h1E; prog[9] = 8'h81; prog[10] = 8'hF0;
      prog[12] = 8'h00; prog[13] = 8'h11; prog[14] = 8'h55;
      run_prog("R9 jumps");
      chk("R9 path acc", acc_out, 8'h55);

      // R10 unused opcodes and NOP
      clear_prog();
      prog[0] = 8'h1F; prog[1] = 8'h93; prog[2] = 8'hA3; prog[3] = 8'hB3;
      prog[4] = 8'hC3; prog[5] = 8'hD3; prog[6] = 8'hE3; prog[7] = 8'h05;
      prog[8] = 8'hF0; prog[15] = 8'h7F;
      run_prog("R10 unused");
      chk("R10 acc kept", acc_out, 8'h7F);

      // R2 wrap 15->0 with self-modifying store
      clear_prog();
      prog[0] = 8'h1E; prog[1] = 8'h7F; prog[14] = 8'hF0; prog[15] = 8'h20;
      run_prog("R2 wrap");
      chk("R2 wrap cycles", cycle_cnt, 26);

      // R4 load keeps carry
      clear_prog();
      prog[0] = 8'h1A; prog[1] = 8'h3B; prog[2] = 8'h1C; prog[3] = 8'hF0;
      prog[10] = 8'hFF; prog[11] = 8'h02; prog[12] = 8'h00;
      run_prog("R4 load");
      chk("R4 carry kept", flags_out, 3'b011);

      // R3 random programs through the decode map
      for (int t = 0; t < 30; t++) begin
         bit ok = 0;
         while (!ok) begin
            for (int i = 0; i < 16; i++) prog[i] = 8'($urandom);
            run_model(ok);
         end
         run_prog("R3 random");
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule